// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents the single most urgent one to a processor, together with the line number, its priority and a handler address that software can rewrite. Each line chooses where its request comes from: a fixed-function peripheral, a DMA completion, or a signal routed out of programmable logic. A rising edge on the chosen input latches a pending flag. Software can also force or drop that flag, enable or mask the line, and change its priority, source and handler address through a simple one-cycle write port.

The processor side is a request/acknowledge handshake. When the processor acknowledges, the controller clears the granted line's pending flag and takes on that line's priority as the level now being serviced. Only a strictly more urgent request can then interrupt. An end-of-service pulse returns to the level that was active before, kept in a small stack inside the block. A combinational read port returns the full configuration and pending state of any one line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line has pending 0, enable 0, priority 7, source code 0, and handler address VEC_BASE + 4 × line number (0x0100 + 4n by default). `irq_req` and `active_valid` are 0.
- R2: Source codes are 0 = fixed-function input, 1 = DMA input, 2 = logic input, 3 = none. A 0-to-1 change of the selected input sets the line's pending flag on the next clock edge. The unselected inputs have no effect.
- R3: A pending flag stays set until it is acknowledged or cleared by software. An input that is held high does not set the flag again.
- R4: Write op 0 sets the pending flag of `cfg_line`, and op 1 clears it. If a set and a clear (software clear or acknowledge) reach the same line in the same cycle, the set wins.
- R5: Op 2 writes the enable bit from `cfg_wdata[0]`. A pending flag on a disabled line is kept but never presented.
- R6: Among lines that are both pending and enabled, the lowest priority number wins. On a tie, the lowest line number wins. `irq_id`, `irq_prio` and `irq_vector` describe the winner.
- R7: Op 3 writes the priority from `cfg_wdata[2:0]`, op 4 writes the handler address from `cfg_wdata[15:0]`, and op 5 writes the source code from `cfg_wdata[1:0]`. Each write takes effect from the next cycle, even on a line that is already pending. Ops 6 and 7 change nothing.
- R8: `cpu_ack` while `irq_req` is high does three things: it clears the granted line's pending flag, it sets `active_valid` with `active_level` equal to that line's priority, and it saves the prior active state. `cpu_ack` without `irq_req` is ignored.
- R9: While `active_valid` is set, a winner is presented only if its priority number is strictly below `active_level`.
- R10: `cpu_eoi` restores the most recently saved active state. `cpu_eoi` is ignored when nothing is saved, and it is also ignored in a cycle where an acknowledge is taken.
- R11: `rd_pending`, `rd_enable`, `rd_prio`, `rd_vector` and `rd_source` show the current state of line `rd_line` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_fixed | input | 32 | Fixed-function request inputs, one per line |
| src_dma | input | 32 | DMA completion inputs, one per line |
| src_logic | input | 32 | Programmable-logic request inputs, one per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Write operation code |
| cfg_line | input | 5 | Line addressed by the write |
| cfg_wdata | input | 16 | Write data |
| rd_line | input | 5 | Line shown on the read port |
| rd_pending | output | 1 | Pending flag of `rd_line` |
| rd_enable | output | 1 | Enable bit of `rd_line` |
| rd_prio | output | 3 | Priority of `rd_line` |
| rd_vector | output | 16 | Handler address of `rd_line` |
| rd_source | output | 2 | Source code of `rd_line` |
| irq_req | output | 1 | A request is presented to the processor |
| irq_id | output | 5 | Line number of the presented request |
| irq_prio | output | 3 | Priority of the presented request |
| irq_vector | output | 16 | Handler address of the presented request |
| cpu_ack | input | 1 | Processor accepts the presented request |
| cpu_eoi | input | 1 | Processor ends service of the active level |
| active_level | output | 3 | Priority level now in service |
| active_valid | output | 1 | A level is in service |

## Verification
The bench targets five kinds of error:
- Ties between equal priorities: a resolver with the wrong tie rule would hand the processor the higher-numbered line.
- Equal-priority requests during service: a non-strict compare would let them preempt.
- Nested service: a controller that forgets the stacked level would return to idle or to the wrong level after the inner handler ends, and would present or hide the remaining requests wrongly.
- Source handling: a design that ORs all three inputs or triggers on level rather than edge would re-latch a held input, or react to an unselected one.
- Same-cycle conflicts: a design that lets a clear beat a new edge would lose an interrupt. A design that acts on an extra end-of-service pulse would pop an empty stack.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    OP_SET_PEND = 3'd0,
    OP_CLR_PEND = 3'd1,
    OP_ENABLE   = 3'd2,
    OP_PRIO     = 3'd3,
    OP_VECTOR   = 3'd4,
    OP_SOURCE   = 3'd5
  } cfg_op_e;

  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_DMA   = 2'd1,
    SRC_LOGIC = 2'd2,
    SRC_NONE  = 2'd3
  } src_sel_e;

  // Reset handler address of a line.
  function automatic int unsigned reset_vector(int unsigned base, int unsigned stride,
                                               int unsigned line);
    return base + stride * line;
  endfunction

  // True when priority a is strictly more urgent than b (smaller number).
  function automatic logic more_urgent(logic [7:0] a, logic [7:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_pkg::*;
#(
  parameter int N          = 32,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 256,
  parameter int VEC_STRIDE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              src_fixed,
  input  logic [N-1:0]              src_dma,
  input  logic [N-1:0]              src_logic,
  input  logic                      cfg_we,
  input  logic [2:0]                cfg_op,
  input  logic [$clog2(N)-1:0]      cfg_line,
  input  logic [VEC_W-1:0]          cfg_wdata,
  input  logic [N-1:0]              ack_clr,
  output logic [N-1:0]              pend_q,
  output logic [N-1:0]              en_q,
  output logic [N-1:0][PRIO_W-1:0]  prio_q,
  output logic [N-1:0][VEC_W-1:0]   vec_q,
  output logic [N-1:0][1:0]         sel_q,
  output logic [N-1:0]              set_evt
);

  localparam int LINE_W = $clog2(N);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic              hit;
    logic              sel_sig;
    logic              prev_r;
    logic              rise;
    logic              sw_set;
    logic              sw_clr;
    logic              pend_r;
    logic              en_r;
    logic [PRIO_W-1:0] prio_r;
    logic [VEC_W-1:0]  vec_r;
    logic [1:0]        sel_r;

    assign hit = cfg_we && (cfg_line == LINE_W'(i));

    always_comb begin
      case (src_sel_e'(sel_r))
        SRC_FIXED: sel_sig = src_fixed[i];
        SRC_DMA:   sel_sig = src_dma[i];
        SRC_LOGIC: sel_sig = src_logic[i];
        default:   sel_sig = 1'b0;
      endcase
    end

    assign rise   = sel_sig & ~prev_r;
    assign sw_set = hit && (cfg_op == OP_SET_PEND);
    assign sw_clr = hit && (cfg_op == OP_CLR_PEND);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_r <= 1'b0;
        pend_r <= 1'b0;
        en_r   <= 1'b0;
        prio_r <= '1;
        vec_r  <= VEC_W'(reset_vector(VEC_BASE, VEC_STRIDE, i));
        sel_r  <= SRC_FIXED;
      end else begin
        prev_r <= sel_sig;
        // setting events win over clearing ones in the same cycle
        pend_r <= (pend_r & ~(sw_clr | ack_clr[i])) | rise | sw_set;
        if (hit && cfg_op == OP_ENABLE) en_r   <= cfg_wdata[0];
        if (hit && cfg_op == OP_PRIO)   prio_r <= cfg_wdata[PRIO_W-1:0];
        if (hit && cfg_op == OP_VECTOR) vec_r  <= cfg_wdata;
        if (hit && cfg_op == OP_SOURCE) sel_r  <= cfg_wdata[1:0];
      end
    end

    assign pend_q[i]  = pend_r;
    assign en_q[i]    = en_r;
    assign prio_q[i]  = prio_r;
    assign vec_q[i]   = vec_r;
    assign sel_q[i]   = sel_r;
    assign set_evt[i] = rise | sw_set;
  end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int PRIO_W = 3
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     best_valid,
  output logic [$clog2(N)-1:0]     best_id,
  output logic [PRIO_W-1:0]        best_prio
);

  localparam int LINE_W = $clog2(N);

  // Linear scan; strict compare keeps the lower index on ties.
  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!best_valid || more_urgent(8'(prio[i]), 8'(best_prio)))) begin
        best_valid = 1'b1;
        best_id    = LINE_W'(i);
        best_prio  = prio[i];
      end
    end
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [PRIO_W-1:0]        push_level,
  output logic                     act_valid,
  output logic [PRIO_W-1:0]        act_level,
  output logic [$clog2(DEPTH):0]   depth_cnt
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0][PRIO_W:0] slots;
  logic [PTR_W-1:0]           top_idx;

  assign top_idx = PTR_W'(depth_cnt - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots     <= '0;
      act_valid <= 1'b0;
      act_level <= '0;
      depth_cnt <= '0;
    end else if (push) begin
      slots[depth_cnt[PTR_W-1:0]] <= {act_valid, act_level};
      act_valid <= 1'b1;
      act_level <= push_level;
      depth_cnt <= depth_cnt + CNT_W'(1);
    end else if (pop && depth_cnt != '0) begin
      {act_valid, act_level} <= slots[top_idx];
      depth_cnt <= depth_cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 256,
  parameter int VEC_STRIDE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LINES-1:0]         src_fixed,
  input  logic [NUM_LINES-1:0]         src_dma,
  input  logic [NUM_LINES-1:0]         src_logic,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_op,
  input  logic [$clog2(NUM_LINES)-1:0] cfg_line,
  input  logic [VEC_W-1:0]             cfg_wdata,
  input  logic [$clog2(NUM_LINES)-1:0] rd_line,
  output logic                         rd_pending,
  output logic                         rd_enable,
  output logic [PRIO_W-1:0]            rd_prio,
  output logic [VEC_W-1:0]             rd_vector,
  output logic [1:0]                   rd_source,
  output logic                         irq_req,
  output logic [$clog2(NUM_LINES)-1:0] irq_id,
  output logic [PRIO_W-1:0]            irq_prio,
  output logic [VEC_W-1:0]             irq_vector,
  input  logic                         cpu_ack,
  input  logic                         cpu_eoi,
  output logic [PRIO_W-1:0]            active_level,
  output logic                         active_valid
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int DEPTH  = 1 << PRIO_W;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic [NUM_LINES-1:0]             pend_q;
  logic [NUM_LINES-1:0]             en_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_q;
  logic [NUM_LINES-1:0][1:0]        sel_q;
  logic [NUM_LINES-1:0]             set_evt;
  logic [NUM_LINES-1:0]             cand;
  logic [NUM_LINES-1:0]             grant_vec;
  logic [NUM_LINES-1:0]             ack_clr;
  logic                             best_valid;
  logic [LINE_W-1:0]                best_id;
  logic [PRIO_W-1:0]                best_prio;
  logic                             present;
  logic                             ack_fire;
  logic                             eoi_take;
  logic [CNT_W-1:0]                 stack_cnt;

  irq_line_bank #(
    .N(NUM_LINES), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .src_fixed(src_fixed), .src_dma(src_dma), .src_logic(src_logic),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line), .cfg_wdata(cfg_wdata),
    .ack_clr(ack_clr),
    .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q), .vec_q(vec_q),
    .sel_q(sel_q), .set_evt(set_evt)
  );

  assign cand = pend_q & en_q;

  irq_resolver #(.N(NUM_LINES), .PRIO_W(PRIO_W)) u_resolve (
    .cand(cand), .prio(prio_q),
    .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio)
  );

  // Preemption gate: strictly more urgent than the level in service.
  assign present  = best_valid &&
                    (!active_valid || more_urgent(8'(best_prio), 8'(active_level)));
  assign ack_fire = cpu_ack && present;
  assign eoi_take = cpu_eoi && !ack_fire;

  always_comb begin
    grant_vec = '0;
    if (present) grant_vec[best_id] = 1'b1;
  end
  assign ack_clr = ack_fire ? grant_vec : '0;

  irq_level_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(ack_fire), .pop(eoi_take), .push_level(best_prio),
    .act_valid(active_valid), .act_level(active_level), .depth_cnt(stack_cnt)
  );

  assign irq_req    = present;
  assign irq_id     = best_id;
  assign irq_prio   = best_prio;
  assign irq_vector = vec_q[best_id];

  assign rd_pending = pend_q[rd_line];
  assign rd_enable  = en_q[rd_line];
  assign rd_prio    = prio_q[rd_line];
  assign rd_vector  = vec_q[rd_line];
  assign rd_source  = sel_q[rd_line];

endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  parameter int CNT_W     = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [2:0]                   cfg_op,
  input logic [$clog2(NUM_LINES)-1:0] cfg_line,
  input logic                         cpu_ack,
  input logic                         cpu_eoi,
  input logic                         irq_req,
  input logic [$clog2(NUM_LINES)-1:0] irq_id,
  input logic [PRIO_W-1:0]            irq_prio,
  input logic                         active_valid,
  input logic [PRIO_W-1:0]            active_level,
  input logic [NUM_LINES-1:0]         pend_q,
  input logic [NUM_LINES-1:0]         en_q,
  input logic [NUM_LINES-1:0]         set_evt,
  input logic [NUM_LINES-1:0]         grant_vec,
  input logic                         ack_fire,
  input logic [CNT_W-1:0]             stack_cnt
);

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_req_enabled_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[irq_id] && pend_q[irq_id]));

  assert_ack_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (active_valid && active_level == $past(irq_prio)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (!pend_q[$past(irq_id)] || $past(set_evt[irq_id])));

  assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_op == 3'd0) |=> pend_q[$past(cfg_line)]);

  assert_empty_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !cpu_ack && stack_cnt == '0) |=> ($stable(active_valid) && $stable(active_level)));

  assert_stack_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_cnt <= CNT_W'(1 << PRIO_W));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(
  .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line),
  .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .irq_req(irq_req), .irq_id(irq_id),
  .irq_prio(irq_prio), .active_valid(active_valid), .active_level(active_level),
  .pend_q(pend_q), .en_q(en_q), .set_evt(set_evt), .grant_vec(grant_vec),
  .ack_fire(ack_fire), .stack_cnt(stack_cnt)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  localparam logic [2:0] W_SET = 3'd0, W_CLR = 3'd1, W_EN = 3'd2,
                         W_PRIO = 3'd3, W_VEC = 3'd4, W_SRC = 3'd5;

  // {lineA, prioA, lineB, prioB, expected winner}
  localparam int NVEC = 6;
  localparam logic [20:0] VECS [NVEC] = '{
    {5'd3,  3'd5, 5'd9,  3'd2, 5'd9},
    {5'd4,  3'd1, 5'd20, 3'd1, 5'd4},
    {5'd31, 3'd0, 5'd0,  3'd0, 5'd0},
    {5'd10, 3'd6, 5'd11, 3'd7, 5'd10},
    {5'd17, 3'd3, 5'd2,  3'd3, 5'd2},
    {5'd7,  3'd0, 5'd8,  3'd4, 5'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_fixed = '0, src_dma = '0, src_logic = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_op = '0;
  logic [4:0]  cfg_line = '0;
  logic [15:0] cfg_wdata = '0;
  logic [4:0]  rd_line = '0;
  logic        rd_pending, rd_enable;
  logic [2:0]  rd_prio;
  logic [15:0] rd_vector;
  logic [1:0]  rd_source;
  logic        irq_req;
  logic [4:0]  irq_id;
  logic [2:0]  irq_prio;
  logic [15:0] irq_vector;
  logic        cpu_ack = 1'b0, cpu_eoi = 1'b0;
  logic [2:0]  active_level;
  logic        active_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_fixed(src_fixed), .src_dma(src_dma),
    .src_logic(src_logic), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line),
    .cfg_wdata(cfg_wdata), .rd_line(rd_line), .rd_pending(rd_pending),
    .rd_enable(rd_enable), .rd_prio(rd_prio), .rd_vector(rd_vector),
    .rd_source(rd_source), .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
    .irq_vector(irq_vector), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
    .active_level(active_level), .active_valid(active_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input int line, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = op; cfg_line = 5'(line); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic eoi();
    @(negedge clk); cpu_eoi = 1'b1;
    @(negedge clk); cpu_eoi = 1'b0;
  endtask

  task automatic line_on(input int line, input int prio);
    wr(W_PRIO, line, prio);
    wr(W_EN, line, 1);
    wr(W_SET, line, 0);
  endtask

  task automatic line_off(input int line);
    wr(W_CLR, line, 0);
    wr(W_EN, line, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 active_valid", int'(active_valid), 0);
    rd_line = 5'd0; #1;
    chk("R1 pending", int'(rd_pending), 0);
    chk("R1 enable", int'(rd_enable), 0);
    chk("R1 prio", int'(rd_prio), 7);
    chk("R1 source", int'(rd_source), 0);
    chk("R1 vector0", int'(rd_vector), 16'h0100);
    rd_line = 5'd31; #1;
    chk("R1 vector31", int'(rd_vector), 16'h0100 + 4 * 31);

    // R8 ack with nothing presented is ignored
    ack();
    chk("R8 ack ignored", int'(active_valid), 0);

    // R6 table of priority contests
    for (int k = 0; k < NVEC; k++) begin
      logic [20:0] v;
      v = VECS[k];
      line_on(int'(v[20:16]), int'(v[15:13]));
      line_on(int'(v[12:8]), int'(v[7:5]));
      chk("R6 req", int'(irq_req), 1);
      chk("R6 winner", int'(irq_id), int'(v[4:0]));
      chk("R6 vector", int'(irq_vector), 16'h0100 + 4 * int'(v[4:0]));
      line_off(int'(v[20:16]));
      line_off(int'(v[12:8]));
    end

    // R5 disabled pending kept but not presented
    wr(W_SET, 14, 0);
    rd_line = 5'd14; #1;
    chk("R5 pending kept", int'(rd_pending), 1);
    chk("R5 not presented", int'(irq_req), 0);
    wr(W_EN, 14, 1);
    chk("R5 presented", int'(irq_req), 1);
    chk("R5 id", int'(irq_id), 14);
    line_off(14);

    // R2 / R3 source selection and edge detection on line 5
    wr(W_SRC, 5, 1);
    wr(W_EN, 5, 1);
    rd_line = 5'd5;
    @(negedge clk); src_fixed[5] = 1'b1;
    @(negedge clk); src_fixed[5] = 1'b0;
    chk("R2 unselected ignored", int'(rd_pending), 0);
    src_dma[5] = 1'b1;
    @(negedge clk);
    chk("R2 dma edge", int'(rd_pending), 1);
    chk("R2 presented id", int'(irq_id), 5);
    wr(W_CLR, 5, 0);
    repeat (2) @(negedge clk);
    chk("R3 held level no reset", int'(rd_pending), 0);
    wr(W_SRC, 5, 3);
    src_dma[5] = 1'b0;
    @(negedge clk); src_dma[5] = 1'b1;
    @(negedge clk); src_dma[5] = 1'b0;
    chk("R2 source none", int'(rd_pending), 0);
    wr(W_SRC, 5, 2);
    chk("R11 source read", int'(rd_source), 2);
    @(negedge clk); src_logic[5] = 1'b1;
    @(negedge clk); src_logic[5] = 1'b0;
    chk("R2 logic edge", int'(rd_pending), 1);
    repeat (2) @(negedge clk);
    chk("R3 pending holds", int'(rd_pending), 1);
    line_off(5);

    // R4 set beats clear in the same cycle (hw edge vs sw clear)
    wr(W_EN, 8, 1);
    rd_line = 5'd8;
    @(negedge clk);
    src_fixed[8] = 1'b1;
    cfg_we = 1'b1; cfg_op = W_CLR; cfg_line = 5'd8;
    @(negedge clk);
    cfg_we = 1'b0; src_fixed[8] = 1'b0;
    chk("R4 set wins", int'(rd_pending), 1);
    wr(W_CLR, 8, 0);
    chk("R4 sw clear", int'(rd_pending), 0);
    wr(W_EN, 8, 0);

    // R7 live rewrite of vector and priority, R11 readback
    line_on(9, 2);
    wr(W_VEC, 9, 16'hBEEF);
    chk("R7 vector rewrite", int'(irq_vector), 16'hBEEF);
    wr(W_PRIO, 9, 6);
    chk("R7 prio rewrite", int'(irq_prio), 6);
    wr(3'd6, 9, 0);
    rd_line = 5'd9; #1;
    chk("R7 op6 no effect", int'(rd_prio), 6);
    chk("R11 vector read", int'(rd_vector), 16'hBEEF);
    chk("R11 enable read", int'(rd_enable), 1);
    line_off(9);

    // R8 / R9 / R10 nesting
    line_on(6, 4);
    chk("R8 pre id", int'(irq_id), 6);
    ack();
    rd_line = 5'd6; #1;
    chk("R8 pending cleared", int'(rd_pending), 0);
    chk("R8 active level", int'(active_level), 4);
    chk("R8 active valid", int'(active_valid), 1);
    line_on(12, 5);
    chk("R9 lower blocked", int'(irq_req), 0);
    line_on(13, 4);
    chk("R9 equal blocked", int'(irq_req), 0);
    line_on(2, 1);
    chk("R9 higher presented", int'(irq_id), 2);
    ack();
    chk("R8 nested level", int'(active_level), 1);
    eoi();
    chk("R10 restore level", int'(active_level), 4);
    chk("R10 restore valid", int'(active_valid), 1);
    chk("R10 still blocked", int'(irq_req), 0);
    eoi();
    chk("R10 idle", int'(active_valid), 0);
    chk("R6 next winner", int'(irq_id), 13);
    eoi();
    chk("R10 empty eoi", int'(active_valid), 0);
    chk("R10 empty eoi req", int'(irq_req), 1);
    ack();
    chk("R8 level 13", int'(active_level), 4);
    eoi();
    chk("R9 12 presented", int'(irq_id), 12);
    @(negedge clk); cpu_ack = 1'b1; cpu_eoi = 1'b1;
    @(negedge clk); cpu_ack = 1'b0; cpu_eoi = 1'b0;
    chk("R10 eoi with ack ignored", int'(active_level), 5);
    chk("R10 eoi with ack valid", int'(active_valid), 1);
    eoi();
    chk("R10 final idle", int'(active_valid), 0);
    chk("R8 final no req", int'(irq_req), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule